// File: doc/BRIEF.md
# Filtered Pin Edge Detector

This block takes an asynchronous input pin belonging to a timer and turns accepted transitions on it into a single-cycle strobe in the system clock domain. The strobe is used either as a capture trigger or as a count clock. The pin first passes through a synchronizer. It is then sampled only on cycles where the chosen sample tick is high. A new level is taken as the filtered level only after it has been seen on a set number of consecutive ticks, so short noise pulses are dropped.

Two sample tick inputs are provided because counting and capture may call for different sampling rates. A select input picks which of the two is used. A two-bit field chooses which transitions of the filtered level count as valid. The operation enable gates the strobe. While the block is stopped, the filtered level keeps following the pin.

The edge history follows the pin differently before and after the first enable. From reset until the first enable, the history holds low. A pin that is already high at that first enable therefore produces a rising edge. After the block has run once, the history keeps following the filtered level while the block is stopped, so a re-enable with the pin high produces no edge.

Top module: `pin_edge_filter`

## Requirements
- R1: The pin passes through SYNC_STAGES flops and is then sampled only on cycles where the selected tick is high. When `tick_sel`=0 the tick is `smp_tick_a`; when `tick_sel`=1 it is `smp_tick_b`. The filtered level never changes on a cycle without a selected tick.
- R2: The filtered level takes a new value only after that value has been sampled on AGREE_SAMPLES consecutive ticks (default 2). A pin pulse seen on fewer ticks produces no strobe.
- R3: `edge_sel` decodes as follows: bit 0 enables rising edges of the filtered level and bit 1 enables falling edges. So 00 selects none, 01 rising, 10 falling and 11 both.
- R4: Each accepted edge gives `edge_stb` high for exactly one clock cycle. `edge_stb` is 0 during reset and out of reset.
- R5: While `run_en`=0, `edge_stb` stays 0, but the filtered level keeps tracking the pin. A later change seen after enabling is measured against the tracked level.
- R6: After reset, if the filtered level is high when `run_en` is first set, a rising edge is reported, provided rising edges are enabled in `edge_sel`.
- R7: After the block has been enabled once, re-enabling with the filtered level high reports no edge.
- R8: Latency: with a tick on every cycle and default parameters, suppose the pin changes before clock edge 1. If that edge is wanted, `edge_stb` is high after edge 5 and low again after edge 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_async | input | 1 | Asynchronous timer input pin |
| smp_tick_a | input | 1 | Sample tick used for counting |
| smp_tick_b | input | 1 | Sample tick used for capture |
| tick_sel | input | 1 | 0 selects smp_tick_a, 1 selects smp_tick_b |
| run_en | input | 1 | Operation enable |
| edge_sel | input | 2 | Valid edge select: bit0 rising, bit1 falling |
| edge_stb | output | 1 | One-cycle strobe per accepted edge |

## Verification
The bench drives pulses one, two and three clocks wide with a tick on every cycle. A filter that accepts a single sample would pass the one-clock glitch. With a slow tick, it checks that a two-clock pulse is rejected, which a design sampling on every clock would fail to do. It sweeps all four edge-select codes over a rise and a fall, which catches swapped or inverted select bits. It then goes after the enable history. It tests a first enable after a reset with the pin held high, once with rising edges selected and once with only falling edges selected. It also tests a re-enable with the pin high, followed by a fall. A design that froze its history while stopped would report a spurious edge on re-enable. A design that froze its filter would miss the fall.

// File: rtl/edf_pkg.sv
`timescale 1ns/1ps
package edf_pkg;
   localparam logic [1:0] EDGE_NONE = 2'b00;
   localparam logic [1:0] EDGE_RISE = 2'b01;
   localparam logic [1:0] EDGE_FALL = 2'b10;
   localparam logic [1:0] EDGE_BOTH = 2'b11;

   function automatic logic edge_wanted(input logic [1:0] sel,
                                        input logic       rise,
                                        input logic       fall);
      return (rise & sel[0]) | (fall & sel[1]);
   endfunction
endpackage

// File: rtl/edf_sync.sv
`timescale 1ns/1ps
module edf_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("edf_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], din};
   end

   assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/edf_filter.sv
`timescale 1ns/1ps
module edf_filter #(
   parameter int AGREE = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_lvl,
   input  logic tick,
   output logic lvl
);
   if (AGREE < 2) begin : g_bad_agree
      $error("edf_filter: AGREE must be at least 2");
   end

   logic [AGREE-1:0] hist_q;
   logic [AGREE-1:0] hist_nx;
   logic             lvl_q;
   logic             all_hi;
   logic             all_lo;

   assign hist_nx = {hist_q[AGREE-2:0], sync_lvl};

   if (AGREE == 2) begin : g_pair
      assign all_hi = hist_q[0] & sync_lvl;
      assign all_lo = ~(hist_q[0] | sync_lvl);
   end else begin : g_wide
      assign all_hi = &hist_nx;
      assign all_lo = ~|hist_nx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
         lvl_q  <= 1'b0;
      end else if (tick) begin
         hist_q <= hist_nx;
         if (all_hi)      lvl_q <= 1'b1;
         else if (all_lo) lvl_q <= 1'b0;
      end
   end

   assign lvl = lvl_q;

   // R1: no tick, no change of filtered level
   p_hold_without_tick_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(lvl_q));
   // R2: a new level must match the synchronized input sampled at that edge
   p_new_level_agrees_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> ($past(sync_lvl) == lvl_q));
endmodule

// File: rtl/edf_edge.sv
`timescale 1ns/1ps
module edf_edge
   import edf_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       lvl,
   input  logic       run_en,
   input  logic [1:0] edge_sel,
   output logic       stb
);
   logic armed_q;
   logic prev_q;
   logic stb_q;
   logic rise;
   logic fall;

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         prev_q  <= 1'b0;
         stb_q   <= 1'b0;
      end else begin
         if (run_en) armed_q <= 1'b1;
         if (run_en | armed_q) prev_q <= lvl;
         stb_q <= run_en & edge_wanted(edge_sel, rise, fall);
      end
   end

   assign stb = stb_q;

   // R4: strobe is a single cycle
   p_single_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |=> !stb_q);
   // R5: stopped block gives no strobe
   p_quiet_when_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !run_en |=> !stb_q);
   // R3: rising-only strobe leaves history high, falling-only leaves it low
   p_rise_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_q && $past(edge_sel) == EDGE_RISE) |-> prev_q);
   p_fall_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (stb_q && $past(edge_sel) == EDGE_FALL) |-> !prev_q);
endmodule

// File: rtl/pin_edge_filter.sv
`timescale 1ns/1ps
module pin_edge_filter #(
   parameter int SYNC_STAGES   = 2,
   parameter int AGREE_SAMPLES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_async,
   input  logic       smp_tick_a,
   input  logic       smp_tick_b,
   input  logic       tick_sel,
   input  logic       run_en,
   input  logic [1:0] edge_sel,
   output logic       edge_stb
);
   logic pin_sync;
   logic tick;
   logic lvl_filt;

   edf_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pin_async),
      .dout  (pin_sync)
   );

   assign tick = tick_sel ? smp_tick_b : smp_tick_a;

   edf_filter #(.AGREE(AGREE_SAMPLES)) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_lvl (pin_sync),
      .tick     (tick),
      .lvl      (lvl_filt)
   );

   edf_edge u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl      (lvl_filt),
      .run_en   (run_en),
      .edge_sel (edge_sel),
      .stb      (edge_stb)
   );
endmodule

// File: tb/pin_edge_filter_tb_top.sv
`timescale 1ns/1ps
module pin_edge_filter_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_async = 1'b0;
   logic       smp_tick_a = 1'b1;
   logic       smp_tick_b = 1'b0;
   logic       tick_sel = 1'b0;
   logic       run_en = 1'b0;
   logic [1:0] edge_sel = 2'b00;
   logic       edge_stb;

   int checks = 0;
   int errors = 0;
   int stb_cnt = 0;
   int tcnt = 0;
   bit done = 0;

   always #2 clk = ~clk;

   pin_edge_filter dut_i (
      .clk(clk), .rst_n(rst_n), .pin_async(pin_async),
      .smp_tick_a(smp_tick_a), .smp_tick_b(smp_tick_b), .tick_sel(tick_sel),
      .run_en(run_en), .edge_sel(edge_sel), .edge_stb(edge_stb)
   );

   // slow tick: one cycle in four
   always @(negedge clk) begin
      tcnt <= (tcnt + 1) % 4;
      smp_tick_b <= (tcnt == 3);
   end

   always @(negedge clk) if (edge_stb) stb_cnt <= stb_cnt + 1;

   task automatic chk(input int act, input int exp, input string req);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic count_win(input int n, output int c);
      @(negedge clk);
      stb_cnt = 0;
      repeat (n) @(negedge clk);
      c = stb_cnt;
   endtask

   task automatic pulse(input int w, output int c);
      @(negedge clk);
      stb_cnt = 0;
      pin_async = 1'b1;
      repeat (w) @(negedge clk);
      pin_async = 1'b0;
      repeat (30) @(negedge clk);
      c = stb_cnt;
   endtask

   task automatic do_reset(input logic pin_lvl);
      @(negedge clk);
      rst_n = 1'b0; run_en = 1'b0; pin_async = pin_lvl;
      wait_n(3);
      rst_n = 1'b1;
   endtask

   initial begin
      int c;
      wait_n(3);
      chk(edge_stb, 0, "R4 reset value");
      rst_n = 1'b1;
      wait_n(10);
      chk(edge_stb, 0, "R4 idle after reset");

      // R8 latency with tick every cycle
      edge_sel = 2'b11; run_en = 1'b1;
      wait_n(5);
      pin_async = 1'b1;
      repeat (4) @(posedge clk);
      #1 chk(edge_stb, 0, "R8 not before edge 5");
      @(posedge clk);
      #1 chk(edge_stb, 1, "R8 high after edge 5");
      @(posedge clk);
      #1 chk(edge_stb, 0, "R4 low after one cycle");
      wait_n(10);

      // R3 sweep over select codes
      for (int s = 0; s < 4; s++) begin
         int fc, rc;
         @(negedge clk);
         edge_sel = s[1:0];
         pin_async = 1'b0;
         count_win(12, fc);
         pin_async = 1'b1;
         count_win(12, rc);
         chk(rc, s & 1, "R3 rising count");
         chk(fc, (s >> 1) & 1, "R3 falling count");
      end

      // R2 glitch widths with tick every cycle
      edge_sel = 2'b11; pin_async = 1'b0;
      wait_n(12);
      pulse(1, c); chk(c, 0, "R2 one-sample pulse rejected");
      pulse(2, c); chk(c, 2, "R2 two-sample pulse accepted");
      pulse(3, c); chk(c, 2, "R2 three-sample pulse accepted");

      // R1 slow tick rejects two-clock pulse
      tick_sel = 1'b1;
      wait_n(12);
      pulse(2, c); chk(c, 0, "R1 slow tick rejects short pulse");
      pulse(12, c); chk(c, 2, "R1 slow tick accepts long pulse");
      tick_sel = 1'b0;
      wait_n(12);

      // R5 stopped: no strobe
      run_en = 1'b0;
      pin_async = 1'b1;
      count_win(12, c); chk(c, 0, "R5 no strobe on rise while stopped");
      pin_async = 1'b0;
      count_win(12, c); chk(c, 0, "R5 no strobe on fall while stopped");
      // R7 re-enable with pin high
      pin_async = 1'b1;
      wait_n(12);
      run_en = 1'b1;
      count_win(12, c); chk(c, 0, "R7 re-enable high gives no edge");
      pin_async = 1'b0;
      count_win(12, c); chk(c, 1, "R5 tracked level then fall seen");

      // R6 first enable after reset with pin high
      do_reset(1'b1);
      wait_n(12);
      edge_sel = 2'b01; run_en = 1'b1;
      count_win(12, c); chk(c, 1, "R6 first enable rising selected");
      do_reset(1'b1);
      wait_n(12);
      edge_sel = 2'b10; run_en = 1'b1;
      count_win(12, c); chk(c, 0, "R6 first enable falling only");
      do_reset(1'b1);
      wait_n(12);
      edge_sel = 2'b11; run_en = 1'b1;
      count_win(12, c); chk(c, 1, "R6 first enable both selected");
      edge_sel = 2'b00;
      pin_async = 1'b0;
      count_win(12, c); chk(c, 0, "R3 none selected");

      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule